// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block steps through a shared table of 64 conversion command words and hands each one to an analog converter over a start/done handshake. Two queues share the table. The high-priority queue (queue 1) is modelled only as an activity input. The low-priority queue (queue 2) is the queue this block runs. Queue 2 begins at a programmable table index, and that same index marks the end of queue 1's part of the table. A 16-bit control word sets the behaviour of queue 2:

- its interrupt enables,
- a single-scan arm bit,
- the operating mode,
- the resume policy,
- the begin index.

Each command word holds a pause flag and a 6-bit channel code. Channel code 63 marks the end of the queue and is never sent to the converter. A pause word splits queue 2 into sub-queues. After the paused conversion completes, the queue waits for a fresh trigger before it continues.

When queue 1 becomes active, it blocks new queue 2 conversions and aborts any queue 2 conversion in flight. When queue 1 goes idle again, queue 2 restarts. A latched resume policy picks the restart point: either the start of the current sub-queue or the aborted command. Completion and pause events set sticky interrupt requests. Software clears these requests by writing 1 to a clear input.

Top module: `scan_sequencer`

## Requirements
- R1: The control word has cie at bit 15, pie at bit 14, arm (single-scan enable) at bit 13, mode at bits 12:8, resume select at bit 7 and the begin index at bits 6:0. A write with `ctl_we` takes effect at the next clock. `ctl_rdata` returns 16'h0040 after reset.
- R2: The arm bit always reads back as 0. A single-scan pass starts only while the arm bit is set, and the hardware clears the bit when the pass ends. A further trigger after that starts nothing.
- R3: Mode 5'b00001 is single-scan started by `sw_trig`. Mode 5'b00010 is single-scan started by `ext_trig`. Mode 5'b10001 is continuous scan started by `sw_trig`. Every other mode code is disabled, and in a disabled mode triggers start nothing. A trigger from the source the mode does not select is ignored.
- R4: Table entries hold {pause at bit 6, channel at bits 5:0} and are written through `tbl_we`/`tbl_waddr`/`tbl_wdata`. A queue 2 pass issues the entries in index order, starting at the begin index, and puts each entry's channel on `conv_chan`.
- R5: Queue 2 ends when it reaches an entry whose channel is 63; that entry is not issued. It also ends after index 63 completes. A begin index of 64 or more makes queue 2 empty, so triggers start nothing.
- R6: When cie is set, `irq_done` rises after queue 2 reaches its end.
- R7: When pie is set, `irq_pause` rises after a pause entry's conversion completes. The next entry then waits for a fresh trigger.
- R8: Interrupt requests stay high until software writes a 1 to the matching `irq_clr` bit (bit 0 clears `irq_done`, bit 1 clears `irq_pause`).
- R9: While `q1_active` is high, no `conv_start` is issued. If `q1_active` rises during a queue 2 conversion, `conv_abort` is high in that same cycle.
- R10: After an abort, queue 2 restarts when `q1_active` falls. With resume select 0 it restarts at the first entry of the current sub-queue; with resume select 1 it restarts at the aborted entry.
- R11: The resume select that governs a pass is latched while queue 2 is idle. A change written during the pass takes effect only at the next end of queue or at a change of mode.
- R12: In continuous mode, the end of the queue restarts the pass at the begin index without a trigger. Writing a different mode stops the queue.
- R13: `conv_start` is a one-cycle pulse. No new start is issued until the previous conversion is done or has been aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word readback (arm bit reads 0) |
| tbl_we | input | 1 | Command table write strobe |
| tbl_waddr | input | 6 | Command table write index |
| tbl_wdata | input | 7 | Command word {pause, channel} |
| sw_trig | input | 1 | Software trigger pulse |
| ext_trig | input | 1 | External trigger pulse |
| q1_active | input | 1 | High-priority queue is requesting or running |
| conv_start | output | 1 | Start a conversion on `conv_chan` |
| conv_chan | output | 6 | Channel of the conversion being started |
| conv_abort | output | 1 | Abandon the conversion in flight |
| conv_done | input | 1 | Converter has finished the current conversion |
| irq_done | output | 1 | Queue 2 completion interrupt request |
| irq_pause | output | 1 | Queue 2 pause interrupt request |
| irq_clr | input | 2 | Write-1-to-clear for {pause, completion} requests |

## Verification
The bench aborts the second entry of a three-entry queue under both resume settings. The channel order after the restart then shows the restart point: a design that ignored the policy would repeat the wrong entry or skip one. It also rewrites the resume bit in the middle of a pass and aborts afterwards, which catches a design that follows the live bit instead of the latched one. The other cases the bench drives are:
- A begin index of 64.
- A queue that ends at index 63 with no end code.
- A pause that must hold the queue until a fresh trigger.
- A mode code that is not defined.
- A trigger from the wrong source.
- A second trigger after a single scan has ended.

A design that got one of these wrong would issue conversions it should not, or drop ones it should issue.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

    localparam int TBL_DEPTH = 64;
    localparam int IDX_W     = $clog2(TBL_DEPTH);
    localparam int CHAN_W    = 6;
    localparam int CCW_W     = CHAN_W + 1;
    localparam int CTL_W     = 16;
    localparam int BEGIN_W   = IDX_W + 1;
    localparam int IRQ_N     = 2;

    localparam logic [CHAN_W-1:0] EOQ_CHAN   = '1;
    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(TBL_DEPTH - 1);
    localparam logic [CTL_W-1:0]  CTL_RESET  = CTL_W'(TBL_DEPTH);

    // control word, MSB first
    typedef struct packed {
        logic               cie;
        logic               pie;
        logic               arm;
        logic [4:0]         mode;
        logic               resume;
        logic [BEGIN_W-1:0] begin_idx;
    } ctl_t;

    typedef struct packed {
        logic              pause;
        logic [CHAN_W-1:0] chan;
    } ccw_t;

    typedef struct packed {
        logic enabled;
        logic single;
        logic cont;
        logic use_ext;
    } mode_dec_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_BUSY,
        S_WAIT,
        S_SUSP
    } seq_state_t;

    function automatic mode_dec_t decode_mode(input logic [4:0] m);
        mode_dec_t d;
        d = '0;
        case (m)
            5'b00001: begin d.enabled = 1'b1; d.single = 1'b1; end
            5'b00010: begin d.enabled = 1'b1; d.single = 1'b1; d.use_ext = 1'b1; end
            5'b10001: begin d.enabled = 1'b1; d.cont   = 1'b1; end
            default:  d = '0;
        endcase
        return d;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_readback(input ctl_t c);
        ctl_t r;
        r     = c;
        r.arm = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ccw_table.sv
module ccw_table #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 7,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/q2_ctl_reg.sv
module q2_ctl_reg
    import scanseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             arm_clr,
    input  logic             eoq_evt,
    input  logic             idle,
    output ctl_t             ctl,
    output logic [CTL_W-1:0] rdata,
    output logic             res_lat,
    output logic             mode_chg
);

    ctl_t wr;
    logic relatch;

    assign wr       = ctl_t'(wdata);
    assign mode_chg = we && (wr.mode != ctl.mode);
    assign relatch  = idle || eoq_evt || mode_chg;
    assign rdata    = ctl_readback(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= ctl_t'(CTL_RESET);
        end else if (we) begin
            ctl <= wr;
        end else if (arm_clr) begin
            ctl.arm <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_lat <= 1'b0;
        end else if (relatch) begin
            res_lat <= we ? wr.resume : ctl.resume;
        end
    end

endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag[i] <= 1'b0;
            end else if (set[i]) begin
                flag[i] <= 1'b1;
            end else if (clr[i]) begin
                flag[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/q2_seq_fsm.sv
module q2_seq_fsm
    import scanseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             res_lat,
    input  logic             mode_chg,
    input  ccw_t             ccw,
    input  logic             sw_trig,
    input  logic             ext_trig,
    input  logic             q1_active,
    input  logic             conv_done,
    output logic [IDX_W-1:0] rd_idx,
    output logic             conv_start,
    output logic             conv_abort,
    output logic             set_done,
    output logic             set_pause,
    output logic             arm_clr,
    output logic             eoq_evt,
    output logic             idle
);

    seq_state_t       state, state_n;
    logic [IDX_W-1:0] ptr, ptr_n;
    logic [IDX_W-1:0] subq, subq_n;
    logic             q1_q;
    logic             fin;
    mode_dec_t        dec;
    logic             trig_hit;
    logic             q2_empty;
    logic             q1_rise;
    logic [IDX_W-1:0] bq;

    assign dec      = decode_mode(ctl.mode);
    assign trig_hit = dec.enabled && (dec.use_ext ? ext_trig : sw_trig);
    assign q2_empty = ctl.begin_idx[BEGIN_W-1];
    assign bq       = ctl.begin_idx[IDX_W-1:0];
    assign q1_rise  = q1_active && !q1_q;
    assign rd_idx   = ptr;
    assign idle     = (state == S_IDLE);

    always_comb begin
        state_n    = state;
        ptr_n      = ptr;
        subq_n     = subq;
        conv_start = 1'b0;
        conv_abort = 1'b0;
        set_pause  = 1'b0;
        fin        = 1'b0;
        case (state)
            S_IDLE: begin
                if (trig_hit && !q2_empty && (dec.cont || ctl.arm)) begin
                    ptr_n   = bq;
                    subq_n  = bq;
                    state_n = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (!q1_active) begin
                    if (ccw.chan == EOQ_CHAN) begin
                        fin = 1'b1;
                    end else begin
                        conv_start = 1'b1;
                        state_n    = S_BUSY;
                    end
                end
            end
            S_BUSY: begin
                if (q1_rise) begin
                    conv_abort = 1'b1;
                    ptr_n      = res_lat ? ptr : subq;
                    state_n    = S_SUSP;
                end else if (conv_done) begin
                    set_pause = ccw.pause && ctl.pie;
                    if (ptr == LAST_IDX) begin
                        fin = 1'b1;
                    end else begin
                        ptr_n = ptr + IDX_W'(1);
                        if (ccw.pause) begin
                            subq_n  = ptr + IDX_W'(1);
                            state_n = S_WAIT;
                        end else begin
                            state_n = S_ISSUE;
                        end
                    end
                end
            end
            S_WAIT: begin
                if (trig_hit) begin
                    state_n = S_ISSUE;
                end
            end
            S_SUSP: begin
                if (!q1_active) begin
                    state_n = S_ISSUE;
                end
            end
            default: state_n = S_IDLE;
        endcase

        eoq_evt  = fin;
        set_done = fin && ctl.cie;
        arm_clr  = fin && dec.single;
        if (fin) begin
            if (dec.cont && !q2_empty) begin
                ptr_n   = bq;
                subq_n  = bq;
                state_n = S_ISSUE;
            end else begin
                state_n = S_IDLE;
            end
        end

        if (mode_chg) begin
            state_n    = S_IDLE;
            conv_start = 1'b0;
            conv_abort = conv_abort || (state == S_BUSY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ptr   <= '0;
            subq  <= '0;
            q1_q  <= 1'b0;
        end else begin
            state <= state_n;
            ptr   <= ptr_n;
            subq  <= subq_n;
            q1_q  <= q1_active;
        end
    end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scanseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_waddr,
    input  logic [CCW_W-1:0]  tbl_wdata,
    input  logic              sw_trig,
    input  logic              ext_trig,
    input  logic              q1_active,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_abort,
    input  logic              conv_done,
    output logic              irq_done,
    output logic              irq_pause,
    input  logic [IRQ_N-1:0]  irq_clr
);

    ctl_t             ctl;
    logic             res_lat;
    logic             mode_chg;
    logic [IDX_W-1:0] rd_idx;
    logic [CCW_W-1:0] rd_word;
    ccw_t             ccw;
    logic             set_done, set_pause;
    logic             arm_clr, eoq_evt, idle;
    logic [IRQ_N-1:0] flags;

    assign ccw       = ccw_t'(rd_word);
    assign conv_chan = ccw.chan;

    ccw_table #(.DEPTH(TBL_DEPTH), .WIDTH(CCW_W)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (rd_idx),
        .rdata (rd_word)
    );

    q2_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .arm_clr  (arm_clr),
        .eoq_evt  (eoq_evt),
        .idle     (idle),
        .ctl      (ctl),
        .rdata    (ctl_rdata),
        .res_lat  (res_lat),
        .mode_chg (mode_chg)
    );

    q2_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .res_lat    (res_lat),
        .mode_chg   (mode_chg),
        .ccw        (ccw),
        .sw_trig    (sw_trig),
        .ext_trig   (ext_trig),
        .q1_active  (q1_active),
        .conv_done  (conv_done),
        .rd_idx     (rd_idx),
        .conv_start (conv_start),
        .conv_abort (conv_abort),
        .set_done   (set_done),
        .set_pause  (set_pause),
        .arm_clr    (arm_clr),
        .eoq_evt    (eoq_evt),
        .idle       (idle)
    );

    irq_flags #(.N(IRQ_N)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  ({set_pause, set_done}),
        .clr  (irq_clr),
        .flag (flags)
    );

    assign irq_done  = flags[0];
    assign irq_pause = flags[1];

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic [15:0] ctl_rdata,
    input logic       q1_active,
    input logic       conv_start,
    input logic [5:0] conv_chan,
    input logic       conv_abort,
    input logic       irq_done,
    input logic       irq_pause,
    input logic [1:0] irq_clr
);

    assert_start_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !q1_active);

    assert_abort_cause_R9: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> ((q1_active && !$past(q1_active)) || ctl_we));

    assert_no_eoq_issue_R5: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (conv_chan != 6'd63));

    assert_start_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_done && !irq_clr[0]) |=> irq_done);

    assert_pause_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_pause && !irq_clr[1]) |=> irq_pause);

    assert_done_enable_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_done) |-> $past(ctl_rdata[15]));

    assert_pause_enable_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pause) |-> $past(ctl_rdata[14]));

endmodule

bind scan_sequencer scan_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ctl_rdata  (ctl_rdata),
    .q1_active  (q1_active),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_abort (conv_abort),
    .irq_done   (irq_done),
    .irq_pause  (irq_pause),
    .irq_clr    (irq_clr)
);

// File: tb/test_scan_sequencer.sv
`timescale 1ns/1ps
module test_scan_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_waddr = '0;
    logic [6:0]  tbl_wdata = '0;
    logic        sw_trig = 1'b0;
    logic        ext_trig = 1'b0;
    logic        q1_active = 1'b0;
    logic        conv_start;
    logic [5:0]  conv_chan;
    logic        conv_abort;
    logic        conv_done;
    logic        irq_done;
    logic        irq_pause;
    logic [1:0]  irq_clr = '0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    scan_sequencer i_scan_sequencer (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .sw_trig(sw_trig), .ext_trig(ext_trig),
        .q1_active(q1_active), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_abort(conv_abort), .conv_done(conv_done), .irq_done(irq_done),
        .irq_pause(irq_pause), .irq_clr(irq_clr)
    );

    // converter model: done four cycles after start unless aborted
    logic [5:0] log_ch [64];
    int         nlog = 0;
    int         busy_starts = 0;
    int         cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            cnt       <= 0;
            conv_done <= 1'b0;
        end else begin
            conv_done <= 1'b0;
            if (conv_abort) begin
                cnt <= 0;
            end else if (conv_start) begin
                if (cnt != 0) busy_starts <= busy_starts + 1;
                if (nlog < 64) log_ch[nlog] <= conv_chan;
                nlog <= nlog + 1;
                cnt  <= 4;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) conv_done <= 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input bit cie, input bit pie, input bit arm,
                                       input logic [4:0] mode, input bit res,
                                       input logic [6:0] bq);
        return {cie, pie, arm, mode, res, bq};
    endfunction

    task automatic write_ctl(input logic [15:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_ccw(input int idx, input bit p, input int ch);
        @(negedge clk); tbl_we = 1'b1; tbl_waddr = 6'(idx); tbl_wdata = {p, 6'(ch)};
        @(negedge clk); tbl_we = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
    endtask

    task automatic clear_irqs();
        @(negedge clk); irq_clr = 2'b11;
        @(negedge clk); irq_clr = 2'b00;
    endtask

    task automatic wait_starts(input int n, input int lim);
        for (int i = 0; i < lim && nlog < n; i++) @(negedge clk);
    endtask

    task automatic wait_done_irq(input int lim);
        for (int i = 0; i < lim && !irq_done; i++) @(negedge clk);
    endtask

    task automatic check_seq(input int base, input int exp_n, input int e0, input int e1,
                             input int e2, input int e3, input int e4, input string req);
        int e [5];
        e = '{e0, e1, e2, e3, e4};
        check(nlog - base == exp_n, req, "start count", nlog - base, exp_n);
        for (int i = 0; i < exp_n && i < 5; i++)
            check(log_ch[base + i] == 6'(e[i]), req, $sformatf("channel #%0d", i),
                  log_ch[base + i], e[i]);
    endtask

    task automatic t_reset();
        check(ctl_rdata == 16'h0040, "R1", "reset readback", ctl_rdata, 16'h0040);
        check(!irq_done && !irq_pause, "R8", "irqs low at reset", {irq_pause, irq_done}, 0);
        check(nlog == 0, "R5", "no starts at reset", nlog, 0);
    endtask

    task automatic t_regfmt();
        write_ctl(mk(1, 0, 1, 5'b00000, 1, 7'd5));
        tick(1);
        check(ctl_rdata == 16'h8085, "R1", "field layout readback", ctl_rdata, 16'h8085);
        check(ctl_rdata[13] == 1'b0, "R2", "arm bit reads zero", ctl_rdata[13], 0);
    endtask

    task automatic t_swscan();
        int base;
        wr_ccw(10, 0, 3); wr_ccw(11, 0, 7); wr_ccw(12, 0, 9); wr_ccw(13, 0, 63);
        write_ctl(mk(1, 0, 1, 5'b00001, 0, 7'd10));
        base = nlog;
        pulse_sw();
        wait_done_irq(200);
        check(irq_done, "R6", "completion irq", irq_done, 1);
        check_seq(base, 3, 3, 7, 9, 0, 0, "R4");
        tick(10);
        check(irq_done, "R8", "completion irq held", irq_done, 1);
        check(ctl_rdata == 16'h810A, "R2", "readback after pass", ctl_rdata, 16'h810A);
        base = nlog;
        pulse_sw();
        tick(30);
        check(nlog == base, "R2", "trigger after single scan ignored", nlog - base, 0);
        @(negedge clk); irq_clr = 2'b01;
        @(negedge clk); irq_clr = 2'b00;
        check(!irq_done, "R8", "W1C clears completion irq", irq_done, 0);
    endtask

    task automatic t_modes();
        int base;
        write_ctl(mk(0, 0, 1, 5'b00011, 0, 7'd10));
        base = nlog;
        pulse_sw(); pulse_ext();
        tick(30);
        check(nlog == base, "R3", "undefined mode starts nothing", nlog - base, 0);
        write_ctl(mk(0, 0, 1, 5'b00010, 0, 7'd10));
        pulse_sw();
        tick(30);
        check(nlog == base, "R3", "sw trigger ignored in ext mode", nlog - base, 0);
        pulse_ext();
        wait_starts(base + 3, 200);
        tick(20);
        check_seq(base, 3, 3, 7, 9, 0, 0, "R3");
        check(!irq_done, "R6", "no completion irq with cie clear", irq_done, 0);
    endtask

    task automatic t_empty();
        int base;
        write_ctl(mk(1, 0, 1, 5'b00001, 0, 7'd64));
        base = nlog;
        pulse_sw();
        tick(30);
        check(nlog == base, "R5", "begin index 64 leaves queue empty", nlog - base, 0);
        check(!irq_done, "R5", "empty queue no completion", irq_done, 0);
    endtask

    task automatic t_end63();
        int base;
        wr_ccw(62, 0, 4); wr_ccw(63, 0, 5);
        write_ctl(mk(1, 0, 1, 5'b00001, 0, 7'd62));
        base = nlog;
        pulse_sw();
        wait_done_irq(200);
        tick(10);
        check(irq_done, "R5", "end after index 63", irq_done, 1);
        check_seq(base, 2, 4, 5, 0, 0, 0, "R5");
        clear_irqs();
    endtask

    task automatic t_pause();
        int base;
        wr_ccw(20, 0, 1); wr_ccw(21, 1, 2); wr_ccw(22, 0, 3); wr_ccw(23, 0, 63);
        write_ctl(mk(1, 1, 1, 5'b00001, 0, 7'd20));
        base = nlog;
        pulse_sw();
        for (int i = 0; i < 200 && !irq_pause; i++) @(negedge clk);
        check(irq_pause, "R7", "pause irq", irq_pause, 1);
        tick(30);
        check(nlog - base == 2, "R7", "sub-queue waits for trigger", nlog - base, 2);
        check(!irq_done, "R7", "no completion during pause", irq_done, 0);
        pulse_sw();
        wait_done_irq(200);
        check_seq(base, 3, 1, 2, 3, 0, 0, "R7");
        check(irq_done, "R6", "completion after last sub-queue", irq_done, 1);
        clear_irqs();
        check(!irq_pause, "R8", "W1C clears pause irq", irq_pause, 0);
    endtask

    task automatic abort_run(input bit res, input bit flip_mid, input int e2, input int e3,
                             input int e4, input int exp_n, input string req);
        int base;
        write_ctl(mk(1, 0, 1, 5'b00001, res, 7'd30));
        base = nlog;
        pulse_sw();
        if (flip_mid) write_ctl(mk(1, 0, 1, 5'b00001, !res, 7'd30));
        wait_starts(base + 2, 200);
        q1_active = 1'b1;
        #1;
        check(conv_abort, "R9", "abort in rise cycle", conv_abort, 1);
        tick(20);
        check(nlog - base == 2, "R9", "no start while q1 active", nlog - base, 2);
        @(negedge clk); q1_active = 1'b0;
        wait_done_irq(300);
        check_seq(base, exp_n, 10, 11, e2, e3, e4, req);
        clear_irqs();
    endtask

    task automatic t_resume();
        wr_ccw(30, 0, 10); wr_ccw(31, 0, 11); wr_ccw(32, 0, 12); wr_ccw(33, 0, 63);
        abort_run(0, 0, 10, 11, 12, 5, "R10");
        abort_run(1, 0, 11, 12, 0, 4, "R10");
        abort_run(1, 1, 11, 12, 0, 4, "R11");
    endtask

    task automatic t_cont();
        int base;
        wr_ccw(40, 0, 2); wr_ccw(41, 0, 3); wr_ccw(42, 0, 63);
        write_ctl(mk(1, 0, 0, 5'b10001, 0, 7'd40));
        base = nlog;
        pulse_sw();
        wait_starts(base + 5, 400);
        check_seq(base, 5, 2, 3, 2, 3, 2, "R12");
        check(irq_done, "R12", "completion set in continuous", irq_done, 1);
        write_ctl(mk(0, 0, 0, 5'b00000, 0, 7'd40));
        tick(2);
        base = nlog;
        tick(30);
        check(nlog == base, "R12", "mode change stops queue", nlog - base, 0);
        clear_irqs();
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_regfmt();
        t_swscan();
        t_modes();
        t_empty();
        t_end63();
        t_pause();
        t_resume();
        t_cont();
        check(busy_starts == 0, "R13", "start while converter busy", busy_starts, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule